// File: doc/BRIEF.md
# In-Frame Response Transmit Controller

This block decides when and what a node sends as an in-frame response on a variable-pulse-width serial link. Software writes a three-bit request word and fills a small byte buffer. The block then watches events that the receive side reports for the current frame: end of data with its CRC verdict, end of frame, a normalization bit from another node, IFR bytes from another node, bus errors and lost arbitration.

From these events it tells a symbol transmitter which symbol comes next: a normalization bit, a data byte, a CRC byte or an end-of-data symbol. Each symbol is offered with a request and consumed with an acknowledge. The pulse timing, the CRC arithmetic and the host register bus are outside the block and are reduced to single-cycle strobes.

A request clears itself when its response finishes or is abandoned. A one-cycle status pulse carries a cause code when that happens.

Top module: `ifr_tx_ctrl`

## Requirements
- R1: The request word (bit 2 = single byte without CRC, bit 1 = multi-byte with CRC, bit 0 = multi-byte without CRC) reads back exactly as written on the next cycle. Internally the highest set bit wins, so 3'b011 behaves as multi-byte with CRC and 3'b110 behaves as single byte.
- R2: When a request is pending and an end of data arrives with a good CRC, the first symbol offered is a normalization bit, followed by the buffered bytes.
- R3: If the response window is open with no request yet, and a request is pending in the cycle a foreign normalization bit arrives, no own normalization bit is sent and the bytes follow directly.
- R4: The response window closes at end of frame. A request written afterwards makes no attempt on that frame, stays readable, and starts after the next good end of data.
- R5: A single-byte response is one normalization bit and one data byte, then completion with no CRC and no end-of-data symbol.
- R6: A pending single-byte request is dropped, with no symbol sent, when another node's IFR byte is seen after its normalization bit, or when an end of data arrives with a CRC error.
- R7: A multi-byte request does not start on an end of data with a CRC error, and it remains pending.
- R8: A multi-byte response with CRC sends every buffered byte, then one CRC symbol, then one end-of-data symbol, and then completes. This sequence needs the end-of-data mark to be set.
- R9: A multi-byte response without CRC sends every buffered byte, then one end-of-data symbol, with no CRC symbol. This sequence needs the end-of-data mark to be set.
- R10: A bus error aborts a response in progress or any pending request. Lost arbitration aborts a response in progress. Either abort clears the request.
- R11: If a data byte is due, the buffer is empty and the end-of-data mark is clear, the response aborts as an underrun. A single-byte response with an empty buffer is also an underrun.
- R12: Each completion or abort clears the request word to zero. It raises term_valid for exactly one cycle, with cause 1 = done, 2 = peer response, 3 = receive error, 4 = bus error, 5 = underrun, 6 = lost arbitration.
- R13: Symbol kind codes are 0 = normalization bit, 1 = data byte, 2 = CRC, 3 = end of data. sym_byte is meaningful only for kind 1.
- R14: Buffered bytes leave in write order. Writes beyond BUF_DEPTH unsent bytes are dropped. Any completion or abort empties the buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_req_wr | input | 1 | Write strobe for the request word |
| host_req_wdata | input | 3 | Request word to write |
| host_req_rdata | output | 3 | Request word as last written (zero after termination) |
| host_byte_wr | input | 1 | Push strobe for a response byte |
| host_byte | input | DATA_W | Response byte |
| host_eod_mark | input | 1 | Strobe: the last response byte has been written |
| rx_eod | input | 1 | End of data seen on the received frame |
| rx_crc_ok | input | 1 | CRC verdict, valid with rx_eod |
| rx_eof | input | 1 | End of frame seen |
| rx_norm | input | 1 | Normalization bit from another node seen |
| rx_ifr_byte | input | 1 | IFR byte from another node received |
| bus_err | input | 1 | Bus error detected |
| arb_lost | input | 1 | Arbitration lost while transmitting |
| sym_req | output | 1 | A symbol is offered to the transmitter |
| sym_kind | output | 2 | Kind of offered symbol |
| sym_byte | output | DATA_W | Byte for a data symbol |
| sym_ack | input | 1 | Transmitter takes the offered symbol |
| term_valid | output | 1 | One-cycle termination pulse |
| term_cause | output | 3 | Termination cause, valid with term_valid |

## Verification
A request write is visible on host_req_rdata after the next rising edge. The first symbol is offered in the cycle after the edge that samples rx_eod or rx_norm. Each acknowledged symbol is replaced by the next one one edge later. The termination pulse appears in the cycle after the edge that samples its deciding event.

The bench drives every strobe from a falling edge and samples all outputs on falling edges. Its monitor records a symbol only when it is offered, acknowledges it at the next rising edge, and pops the expected symbol or cause in order. A late, early, missing or duplicated item therefore shows up as a mismatch or as a non-empty queue when the scenario settles.

// File: rtl/ifr_pkg.sv
package ifr_pkg;

  localparam int REQ_W    = 3;
  localparam int REQ_SGL  = 2;
  localparam int REQ_MCRC = 1;
  localparam int REQ_MRAW = 0;

  typedef enum logic [1:0] {
    MODE_NONE   = 2'd0,
    MODE_SINGLE = 2'd1,
    MODE_MCRC   = 2'd2,
    MODE_MNOCRC = 2'd3
  } ifr_mode_e;

  typedef enum logic [1:0] {
    SYM_NB   = 2'd0,
    SYM_DATA = 2'd1,
    SYM_CRC  = 2'd2,
    SYM_EOD  = 2'd3
  } sym_kind_e;

  typedef enum logic [2:0] {
    TC_NONE     = 3'd0,
    TC_DONE     = 3'd1,
    TC_PEER     = 3'd2,
    TC_RXERR    = 3'd3,
    TC_BUSERR   = 3'd4,
    TC_UNDERRUN = 3'd5,
    TC_ARBLOST  = 3'd6
  } term_cause_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_WINDOW  = 3'd1,
    ST_PEER    = 3'd2,
    ST_TX_NB   = 3'd3,
    ST_TX_DATA = 3'd4,
    ST_TX_CRC  = 3'd5,
    ST_TX_EOD  = 3'd6
  } seq_state_e;

endpackage

// File: rtl/ifr_req_reg.sv
module ifr_req_reg
  import ifr_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REQ_W-1:0] wdata,
  input  logic             clr,
  output logic [REQ_W-1:0] raw_q,
  output ifr_mode_e        mode
);

  logic             raw_en;
  logic [REQ_W-1:0] raw_d;

  // Termination has precedence over a same-cycle host write.
  always_comb begin
    raw_en = clr | wr_en;
    raw_d  = clr ? '0 : wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      raw_q <= '0;
    end else if (raw_en) begin
      raw_q <= raw_d;
    end
  end

  // Priority resolution: single > multi with CRC > multi without CRC.
  always_comb begin
    if (raw_q[REQ_SGL]) begin
      mode = MODE_SINGLE;
    end else if (raw_q[REQ_MCRC]) begin
      mode = MODE_MCRC;
    end else if (raw_q[REQ_MRAW]) begin
      mode = MODE_MNOCRC;
    end else begin
      mode = MODE_NONE;
    end
  end

  a_r1_raw_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !clr) |=> (raw_q == $past(wdata)));

  a_r12_clear_on_term: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (raw_q == '0));

endmodule

// File: rtl/ifr_txbuf.sv
module ifr_txbuf #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  input  logic              flush,
  output logic [DATA_W-1:0] head,
  output logic              empty
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr_q, wr_ptr_d, rd_ptr_q, rd_ptr_d;
  logic [CW-1:0]     count_q, count_d;
  logic              do_push, do_pop;

  always_comb begin
    empty   = (count_q == '0);
    do_push = push && (count_q != FULL_CNT) && !flush;
    do_pop  = pop && !empty && !flush;
    head    = mem[rd_ptr_q];
  end

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    count_d  = count_q;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (do_push) begin
        wr_ptr_d = (wr_ptr_q == LAST_IDX) ? '0 : wr_ptr_q + AW'(1);
      end
      if (do_pop) begin
        rd_ptr_d = (rd_ptr_q == LAST_IDX) ? '0 : rd_ptr_q + AW'(1);
      end
      case ({do_push, do_pop})
        2'b10:   count_d = count_q + CW'(1);
        2'b01:   count_d = count_q - CW'(1);
        default: count_d = count_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      count_q  <= '0;
    end else begin
      wr_ptr_q <= wr_ptr_d;
      rd_ptr_q <= rd_ptr_d;
      count_q  <= count_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) begin
      mem[wr_ptr_q] <= push_data;
    end
  end

  // The sequencer pops only a byte it has offered.
  a_r14_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  a_r14_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);

endmodule

// File: rtl/ifr_seq.sv
module ifr_seq
  import ifr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  ifr_mode_e   mode,
  input  logic        eod_mark,
  input  logic        rx_eod,
  input  logic        rx_crc_ok,
  input  logic        rx_eof,
  input  logic        rx_nb,
  input  logic        rx_ifr_byte,
  input  logic        bus_err,
  input  logic        arb_lost,
  input  logic        sym_ack,
  input  logic        buf_empty,
  output logic        buf_pop,
  output logic        term_now,
  output logic        sym_req,
  output sym_kind_e   sym_kind,
  output logic        term_valid,
  output term_cause_e term_cause
);

  seq_state_e  state_q, state_d;
  ifr_mode_e   mode_q, mode_d;
  logic        teod_q, teod_d;
  term_cause_e cause_d;
  logic        tx_active;

  always_comb begin
    tx_active = (state_q == ST_TX_NB) || (state_q == ST_TX_DATA) ||
                (state_q == ST_TX_CRC) || (state_q == ST_TX_EOD);
  end

  always_comb begin
    state_d  = state_q;
    mode_d   = mode_q;
    term_now = 1'b0;
    cause_d  = TC_NONE;
    buf_pop  = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (rx_eod) begin
          if (!rx_crc_ok) begin
            if (mode == MODE_SINGLE) begin
              term_now = 1'b1;
              cause_d  = TC_RXERR;
            end
          end else if (mode != MODE_NONE) begin
            state_d = ST_TX_NB;
            mode_d  = mode;
          end else begin
            state_d = ST_WINDOW;
          end
        end
      end
      ST_WINDOW: begin
        if (rx_nb) begin
          if (mode != MODE_NONE) begin
            state_d = ST_TX_DATA;
            mode_d  = mode;
          end else begin
            state_d = ST_PEER;
          end
        end else if (rx_eof) begin
          state_d = ST_IDLE;
        end else if (mode != MODE_NONE) begin
          state_d = ST_TX_NB;
          mode_d  = mode;
        end
      end
      ST_PEER: begin
        if (rx_ifr_byte && (mode == MODE_SINGLE)) begin
          term_now = 1'b1;
          cause_d  = TC_PEER;
          state_d  = ST_IDLE;
        end else if (rx_eof) begin
          state_d = ST_IDLE;
        end
      end
      ST_TX_NB: begin
        if (sym_ack) begin
          state_d = ST_TX_DATA;
        end
      end
      ST_TX_DATA: begin
        if (!buf_empty) begin
          if (sym_ack) begin
            buf_pop = 1'b1;
            if (mode_q == MODE_SINGLE) begin
              term_now = 1'b1;
              cause_d  = TC_DONE;
              state_d  = ST_IDLE;
            end
          end
        end else if ((mode_q != MODE_SINGLE) && teod_q) begin
          state_d = (mode_q == MODE_MCRC) ? ST_TX_CRC : ST_TX_EOD;
        end else begin
          term_now = 1'b1;
          cause_d  = TC_UNDERRUN;
          state_d  = ST_IDLE;
        end
      end
      ST_TX_CRC: begin
        if (sym_ack) begin
          state_d = ST_TX_EOD;
        end
      end
      ST_TX_EOD: begin
        if (sym_ack) begin
          term_now = 1'b1;
          cause_d  = TC_DONE;
          state_d  = ST_IDLE;
        end
      end
      default: begin
        state_d = ST_IDLE;
      end
    endcase

    if (bus_err) begin
      buf_pop = 1'b0;
      state_d = ST_IDLE;
      if (tx_active || (mode != MODE_NONE)) begin
        term_now = 1'b1;
        cause_d  = TC_BUSERR;
      end else begin
        term_now = 1'b0;
        cause_d  = TC_NONE;
      end
    end else if (arb_lost && tx_active) begin
      buf_pop  = 1'b0;
      state_d  = ST_IDLE;
      term_now = 1'b1;
      cause_d  = TC_ARBLOST;
    end

    if (term_now) begin
      teod_d = 1'b0;
    end else if (eod_mark) begin
      teod_d = 1'b1;
    end else begin
      teod_d = teod_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      mode_q     <= MODE_NONE;
      teod_q     <= 1'b0;
      term_valid <= 1'b0;
      term_cause <= TC_NONE;
    end else begin
      state_q    <= state_d;
      mode_q     <= mode_d;
      teod_q     <= teod_d;
      term_valid <= term_now;
      term_cause <= cause_d;
    end
  end

  always_comb begin
    sym_req = (state_q == ST_TX_NB) || (state_q == ST_TX_CRC) ||
              (state_q == ST_TX_EOD) || ((state_q == ST_TX_DATA) && !buf_empty);
    case (state_q)
      ST_TX_NB:  sym_kind = SYM_NB;
      ST_TX_CRC: sym_kind = SYM_CRC;
      ST_TX_EOD: sym_kind = SYM_EOD;
      default:   sym_kind = SYM_DATA;
    endcase
  end

  a_r3_sync_to_peer: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WINDOW && rx_nb && mode != MODE_NONE && !bus_err)
      |=> (state_q == ST_TX_DATA));

  a_r5_single_kinds: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && mode_q == MODE_SINGLE) |-> (sym_kind == SYM_NB || sym_kind == SYM_DATA));

  a_r8_crc_then_eod: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_CRC && sym_ack && !bus_err && !arb_lost)
      |=> (sym_req && sym_kind == SYM_EOD));

  a_r9_no_crc_symbol: assert property (@(posedge clk) disable iff (!rst_n)
    (sym_req && mode_q == MODE_MNOCRC) |-> (sym_kind != SYM_CRC));

  a_r10_bus_abort: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_active && bus_err) |=> (term_valid && term_cause == TC_BUSERR && !sym_req));

  a_r11_underrun: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_TX_DATA && buf_empty && !teod_q && !bus_err && !arb_lost)
      |=> (term_valid && term_cause == TC_UNDERRUN));

  a_r12_one_cycle_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |=> !term_valid);

endmodule

// File: rtl/ifr_tx_ctrl.sv
module ifr_tx_ctrl
  import ifr_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int BUF_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_req_wr,
  input  logic [2:0]        host_req_wdata,
  output logic [2:0]        host_req_rdata,
  input  logic              host_byte_wr,
  input  logic [DATA_W-1:0] host_byte,
  input  logic              host_eod_mark,
  input  logic              rx_eod,
  input  logic              rx_crc_ok,
  input  logic              rx_eof,
  input  logic              rx_norm,
  input  logic              rx_ifr_byte,
  input  logic              bus_err,
  input  logic              arb_lost,
  output logic              sym_req,
  output logic [1:0]        sym_kind,
  output logic [DATA_W-1:0] sym_byte,
  input  logic              sym_ack,
  output logic              term_valid,
  output logic [2:0]        term_cause
);

  logic        rst_meta, rst_sync_n;
  ifr_mode_e   mode;
  logic        term_now;
  logic        buf_pop, buf_empty;
  sym_kind_e   kind_w;
  term_cause_e cause_w;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  ifr_req_reg u_req (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .wr_en (host_req_wr),
    .wdata (host_req_wdata),
    .clr   (term_now),
    .raw_q (host_req_rdata),
    .mode  (mode)
  );

  ifr_txbuf #(
    .DATA_W (DATA_W),
    .DEPTH  (BUF_DEPTH)
  ) u_buf (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .push      (host_byte_wr),
    .push_data (host_byte),
    .pop       (buf_pop),
    .flush     (term_now),
    .head      (sym_byte),
    .empty     (buf_empty)
  );

  ifr_seq u_seq (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .mode        (mode),
    .eod_mark    (host_eod_mark),
    .rx_eod      (rx_eod),
    .rx_crc_ok   (rx_crc_ok),
    .rx_eof      (rx_eof),
    .rx_nb       (rx_norm),
    .rx_ifr_byte (rx_ifr_byte),
    .bus_err     (bus_err),
    .arb_lost    (arb_lost),
    .sym_ack     (sym_ack),
    .buf_empty   (buf_empty),
    .buf_pop     (buf_pop),
    .term_now    (term_now),
    .sym_req     (sym_req),
    .sym_kind    (kind_w),
    .term_valid  (term_valid),
    .term_cause  (cause_w)
  );

  always_comb begin
    sym_kind   = kind_w;
    term_cause = cause_w;
  end

endmodule

// File: tb/ifr_tx_ctrl_tb_top.sv
module ifr_tx_ctrl_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 50000;

  logic       clk;
  logic       rst_n;
  logic       host_req_wr;
  logic [2:0] host_req_wdata;
  logic [2:0] host_req_rdata;
  logic       host_byte_wr;
  logic [7:0] host_byte;
  logic       host_eod_mark;
  logic       rx_eod, rx_crc_ok, rx_eof, rx_norm, rx_ifr_byte, bus_err, arb_lost;
  logic       sym_req;
  logic [1:0] sym_kind;
  logic [7:0] sym_byte;
  logic       sym_ack;
  logic       term_valid;
  logic [2:0] term_cause;

  int    n_checks = 0;
  int    n_errors = 0;
  int    cyc      = 0;
  bit    mon_on   = 0;
  bit    ack_en   = 1;

  int    exp_sym[$];
  string exp_sym_tag[$];
  int    exp_cause[$];
  string exp_cause_tag[$];

  ifr_tx_ctrl dut_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .host_req_wr    (host_req_wr),
    .host_req_wdata (host_req_wdata),
    .host_req_rdata (host_req_rdata),
    .host_byte_wr   (host_byte_wr),
    .host_byte      (host_byte),
    .host_eod_mark  (host_eod_mark),
    .rx_eod         (rx_eod),
    .rx_crc_ok      (rx_crc_ok),
    .rx_eof         (rx_eof),
    .rx_norm        (rx_norm),
    .rx_ifr_byte    (rx_ifr_byte),
    .bus_err        (bus_err),
    .arb_lost       (arb_lost),
    .sym_req        (sym_req),
    .sym_kind       (sym_kind),
    .sym_byte       (sym_byte),
    .sym_ack        (sym_ack),
    .term_valid     (term_valid),
    .term_cause     (term_cause)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sym_code(input int kind, input int b);
    return (kind * 256) + ((kind == 1) ? b : 0);
  endfunction

  // Monitor: takes offered symbols and termination pulses, compares in order.
  always @(negedge clk) begin : monitor
    int act;
    int exp;
    string tag;
    if (mon_on) begin
      if (sym_req && ack_en) begin
        act = sym_code(int'(sym_kind), int'(sym_byte));
        if (exp_sym.size() == 0) begin
          check(1'b0, "R13 unexpected symbol", act, -1);
        end else begin
          exp = exp_sym.pop_front();
          tag = exp_sym_tag.pop_front();
          check(act == exp, tag, act, exp);
        end
        sym_ack <= 1'b1;
      end else begin
        sym_ack <= 1'b0;
      end
      if (term_valid) begin
        act = int'(term_cause);
        if (exp_cause.size() == 0) begin
          check(1'b0, "R12 unexpected termination", act, -1);
        end else begin
          exp = exp_cause.pop_front();
          tag = exp_cause_tag.pop_front();
          check(act == exp, tag, act, exp);
        end
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG) begin
      n_checks++;
      n_errors++;
      $display("FAIL R12 watchdog actual=%0d expected=%0d", cyc, WATCHDOG);
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr_req(input logic [2:0] v);
    host_req_wr = 1'b1; host_req_wdata = v; tick(); host_req_wr = 1'b0;
  endtask

  task automatic wr_byte(input logic [7:0] b);
    host_byte_wr = 1'b1; host_byte = b; tick(); host_byte_wr = 1'b0;
  endtask

  task automatic mark_last();
    host_eod_mark = 1'b1; tick(); host_eod_mark = 1'b0;
  endtask

  task automatic pulse_eod(input bit ok);
    rx_eod = 1'b1; rx_crc_ok = ok; tick(); rx_eod = 1'b0; rx_crc_ok = 1'b0;
  endtask

  task automatic pulse_eof();
    rx_eof = 1'b1; tick(); rx_eof = 1'b0;
  endtask

  task automatic pulse_norm();
    rx_norm = 1'b1; tick(); rx_norm = 1'b0;
  endtask

  task automatic pulse_ifr();
    rx_ifr_byte = 1'b1; tick(); rx_ifr_byte = 1'b0;
  endtask

  task automatic pulse_buserr();
    bus_err = 1'b1; tick(); bus_err = 1'b0;
  endtask

  task automatic pulse_arb();
    arb_lost = 1'b1; tick(); arb_lost = 1'b0;
  endtask

  task automatic exp_s(input int kind, input int b, input string tag);
    exp_sym.push_back(sym_code(kind, b));
    exp_sym_tag.push_back(tag);
  endtask

  task automatic exp_t(input int cause, input string tag);
    exp_cause.push_back(cause);
    exp_cause_tag.push_back(tag);
  endtask

  task automatic settle(input string tag);
    tick(30);
    check(exp_sym.size() == 0, {tag, " symbols outstanding"}, exp_sym.size(), 0);
    check(exp_cause.size() == 0, {tag, " terminations outstanding"}, exp_cause.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0;
    host_req_wr = 1'b0; host_req_wdata = '0;
    host_byte_wr = 1'b0; host_byte = '0; host_eod_mark = 1'b0;
    rx_eod = 1'b0; rx_crc_ok = 1'b0; rx_eof = 1'b0; rx_norm = 1'b0;
    rx_ifr_byte = 1'b0; bus_err = 1'b0; arb_lost = 1'b0;
    sym_ack = 1'b0;
    tick(3);
    rst_n = 1'b1;
    tick(5);

    // Reset state
    check(host_req_rdata == 3'b000, "R12 reset readback", int'(host_req_rdata), 0);
    check(sym_req == 1'b0, "R13 reset no symbol", int'(sym_req), 0);
    check(term_valid == 1'b0, "R12 reset no pulse", int'(term_valid), 0);
    mon_on = 1;

    // R1 + R8: 011 reads back raw, acts as multi-byte with CRC
    wr_req(3'b011);
    check(host_req_rdata == 3'b011, "R1 raw readback 011", int'(host_req_rdata), 3);
    wr_byte(8'hA1); wr_byte(8'hA2); mark_last();
    exp_s(0, 0, "R2 normalization first");
    exp_s(1, 8'hA1, "R14 byte order 1");
    exp_s(1, 8'hA2, "R14 byte order 2");
    exp_s(2, 0, "R1 R8 CRC symbol");
    exp_s(3, 0, "R8 EOD symbol");
    exp_t(1, "R8 done cause");
    pulse_eod(1'b1);
    settle("R8");
    check(host_req_rdata == 3'b000, "R12 cleared after done", int'(host_req_rdata), 0);

    // R1 + R5: 110 acts as single byte
    wr_byte(8'h5A);
    wr_req(3'b110);
    check(host_req_rdata == 3'b110, "R1 raw readback 110", int'(host_req_rdata), 6);
    exp_s(0, 0, "R5 normalization");
    exp_s(1, 8'h5A, "R1 R5 single data byte");
    exp_t(1, "R5 done without CRC");
    pulse_eod(1'b1);
    settle("R5");

    // R9 + R14: no-CRC multi-byte, fifth byte dropped (depth 4)
    wr_req(3'b001);
    wr_byte(8'h11); wr_byte(8'h22); wr_byte(8'h33); wr_byte(8'h44); wr_byte(8'h99);
    mark_last();
    exp_s(0, 0, "R9 normalization");
    exp_s(1, 8'h11, "R14 order a");
    exp_s(1, 8'h22, "R14 order b");
    exp_s(1, 8'h33, "R14 order c");
    exp_s(1, 8'h44, "R14 order d, overflow dropped");
    exp_s(3, 0, "R9 EOD without CRC");
    exp_t(1, "R9 done cause");
    pulse_eod(1'b1);
    settle("R9");

    // R3: request pending when foreign normalization bit arrives
    wr_byte(8'h3C);
    pulse_eod(1'b1);
    host_req_wr = 1'b1; host_req_wdata = 3'b100; tick();
    host_req_wr = 1'b0; rx_norm = 1'b1;
    exp_s(1, 8'h3C, "R3 byte without own normalization");
    exp_t(1, "R3 done cause");
    tick(); rx_norm = 1'b0;
    settle("R3");

    // R4: request after end of frame waits for next message
    pulse_eod(1'b1);
    pulse_eof();
    wr_byte(8'h44);
    wr_req(3'b100);
    tick(10);
    check(host_req_rdata == 3'b100, "R4 still pending", int'(host_req_rdata), 4);
    check(exp_sym.size() == 0, "R4 no attempt", exp_sym.size(), 0);
    exp_s(0, 0, "R4 normalization on next message");
    exp_s(1, 8'h44, "R4 byte on next message");
    exp_t(1, "R4 done cause");
    pulse_eod(1'b1);
    settle("R4");

    // R6: peer response clears single request
    pulse_eod(1'b1);
    pulse_norm();
    wr_req(3'b100);
    exp_t(2, "R6 peer cause");
    pulse_ifr();
    settle("R6 peer");
    check(host_req_rdata == 3'b000, "R6 cleared by peer", int'(host_req_rdata), 0);

    // R6: CRC error clears single request
    wr_req(3'b100);
    exp_t(3, "R6 receive error cause");
    pulse_eod(1'b0);
    settle("R6 rxerr");
    check(host_req_rdata == 3'b000, "R6 cleared by CRC error", int'(host_req_rdata), 0);

    // R7: multi-byte not started on CRC error, then R10 bus error clears it
    wr_req(3'b010);
    pulse_eod(1'b0);
    tick(10);
    check(host_req_rdata == 3'b010, "R7 multi retained", int'(host_req_rdata), 2);
    check(exp_cause.size() == 0, "R7 no termination", exp_cause.size(), 0);
    exp_t(4, "R10 bus error while pending");
    pulse_buserr();
    settle("R10 pending");
    check(host_req_rdata == 3'b000, "R10 cleared by bus error", int'(host_req_rdata), 0);

    // R10: lost arbitration during transmit
    wr_byte(8'h66);
    wr_req(3'b001);
    ack_en = 0;
    pulse_eod(1'b1);
    check(sym_req && sym_kind == 2'd0, "R2 R13 normalization offered",
          int'({sym_req, sym_kind}), 4);
    exp_t(6, "R10 lost arbitration cause");
    pulse_arb();
    settle("R10 arb");
    ack_en = 1;
    check(host_req_rdata == 3'b000, "R10 cleared by arbitration loss", int'(host_req_rdata), 0);

    // R10: bus error during transmit
    wr_byte(8'h77); wr_byte(8'h78);
    wr_req(3'b010);
    ack_en = 0;
    pulse_eod(1'b1);
    exp_t(4, "R10 bus error in transmit");
    pulse_buserr();
    settle("R10 bus");
    ack_en = 1;

    // R11: underrun; R14 flushed buffers leave only the new byte
    wr_byte(8'h88);
    wr_req(3'b001);
    exp_s(0, 0, "R11 normalization");
    exp_s(1, 8'h88, "R11 R14 only fresh byte after flush");
    exp_t(5, "R11 underrun cause");
    pulse_eod(1'b1);
    settle("R11");
    check(host_req_rdata == 3'b000, "R11 cleared by underrun", int'(host_req_rdata), 0);

    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

endmodule